// File: doc/BRIEF.md
# Dual-Axis Quadrature Position Decoder

This block tracks the angular position of two rotating axes, azimuth and roll, from incremental encoders. Each axis delivers two phase signals offset by a quarter period and an index pulse that fires once per revolution. All three are already single-ended when they arrive. Every edge of either phase signal moves a signed position count by one step. The order in which the two phases change sets the direction of the step. While the index is asserted, the count of that axis is held at zero.

A processor reads the two counts over a small synchronous read port. A single latch strobe copies both live counts into a snapshot bank in the same clock cycle. Reads return the snapshot, so the azimuth and roll values always come from one instant. A per-axis sticky flag records any clock in which both phase signals of that axis changed at once.

Top module: `quad_pos_dual`

## Requirements
- R1: Each of the inputs az_a, az_b, az_z, rl_a, rl_b and rl_z passes through two flip-flops before it is decoded. A change on a phase input reaches the live count at the third rising clock edge after it.
- R2: For one axis, write {A,B} as a 2-bit value. The sequence 00 -> 10 -> 11 -> 01 -> 00 (A leads B) adds one to that axis's count at every transition.
- R3: The reverse sequence 00 -> 01 -> 11 -> 10 -> 00 (B leads A) subtracts one from that axis's count at every transition.
- R4: If A and B of an axis change in the same synchronised cycle, the count is unchanged and that axis's sticky error bit is set. The bit stays set until reset. Address 2 reads the azimuth error in bit 0 and the roll error in bit 1, with all other bits zero.
- R5: Each count is CNT_W bits two's complement and wraps: the maximum positive value plus one gives the most negative value, and zero minus one gives all ones.
- R6: While the synchronised index of an axis is high, that axis's count becomes zero. This holds even if a phase step arrives in the same cycle.
- R7: The two axes are independent. Stimulus on one axis never changes the other axis's count or error bit.
- R8: A one-cycle pulse on snap_i copies both live counts into the snapshot bank at the same edge. Address 0 reads the azimuth snapshot and address 1 reads the roll snapshot. Between strobes, the values read do not follow the live counts.
- R9: rd_data is registered. It takes the addressed value at the rising edge where rd_en is high, and it holds its value while rd_en is low. Address 3 reads as zero.
- R10: After reset, the counts, snapshots, error bits and rd_data are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| az_a | input | 1 | Azimuth phase A |
| az_b | input | 1 | Azimuth phase B |
| az_z | input | 1 | Azimuth index pulse |
| rl_a | input | 1 | Roll phase A |
| rl_b | input | 1 | Roll phase B |
| rl_z | input | 1 | Roll index pulse |
| snap_i | input | 1 | Latch strobe that loads both snapshots |
| rd_en | input | 1 | Read enable |
| rd_addr | input | 2 | Read address: 0 azimuth, 1 roll, 2 error bits, 3 zero |
| rd_data | output | CNT_W | Registered read data |

## Verification
The assertions rely on two assumptions about the inputs. First, outside the illegal case, the synchronised phase pair of an axis moves by at most one legal edge per clock. Second, an index pulse is a level held for at least one clock, so each cycle the count either stays, moves by one, or drops to zero. The bench keeps to this by changing one axis input at a time and then waiting four clocks, which is longer than the synchroniser and counter latency. Every change therefore reaches the decoder on its own. The illegal case is produced deliberately, by flipping both phases on the same clock edge.

// File: rtl/qpd_pkg.sv
package qpd_pkg;
  localparam int NUM_AXES = 2;
  localparam int AXIS_AZ  = 0;
  localparam int AXIS_RL  = 1;

  typedef enum logic [1:0] {
    ADDR_AZ   = 2'd0,
    ADDR_RL   = 2'd1,
    ADDR_ERR  = 2'd2,
    ADDR_NONE = 2'd3
  } qpd_addr_e;
endpackage

// File: rtl/qpd_sync.sv
module qpd_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/qpd_axis.sv
module qpd_axis #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ph_a,
  input  logic             ph_b,
  input  logic             idx,
  output logic [CNT_W-1:0] pos,
  output logic             err
);
  logic [1:0]       prev_q, prev_d;
  logic [1:0]       delta;
  logic             step, bad, up;
  logic [CNT_W-1:0] pos_d;
  logic             err_d;

  always_comb begin
    delta  = {ph_a, ph_b} ^ prev_q;
    step   = ^delta;
    bad    = &delta;
    up     = ph_a ^ prev_q[0];
    prev_d = {ph_a, ph_b};
    err_d  = err | bad;
    pos_d  = pos;
    if (idx) begin
      pos_d = '0;
    end else if (step) begin
      pos_d = up ? pos + 1'b1 : pos - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pos    <= '0;
      err    <= 1'b0;
    end else begin
      prev_q <= prev_d;
      pos    <= pos_d;
      err    <= err_d;
    end
  end
endmodule

// File: rtl/quad_pos_dual.sv
module quad_pos_dual #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             az_a,
  input  logic             az_b,
  input  logic             az_z,
  input  logic             rl_a,
  input  logic             rl_b,
  input  logic             rl_z,
  input  logic             snap_i,
  input  logic             rd_en,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data
);
  import qpd_pkg::*;

  localparam int PAD_W = CNT_W - NUM_AXES;

  logic             rst_meta_q, rst_n_q;
  logic [2:0]       raw_in  [NUM_AXES];
  logic [2:0]       sync_in [NUM_AXES];
  logic [CNT_W-1:0] pos_cnt [NUM_AXES];
  logic [CNT_W-1:0] snap_q  [NUM_AXES];
  logic [CNT_W-1:0] snap_d  [NUM_AXES];
  logic [NUM_AXES-1:0] err_bits;
  logic [CNT_W-1:0] rd_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_q    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_q    <= rst_meta_q;
    end
  end

  assign raw_in[AXIS_AZ] = {az_a, az_b, az_z};
  assign raw_in[AXIS_RL] = {rl_a, rl_b, rl_z};

  for (genvar g = 0; g < NUM_AXES; g++) begin : g_axis
    qpd_sync #(.W(3)) u_sync (
      .clk   (clk),
      .rst_n (rst_n_q),
      .d     (raw_in[g]),
      .q     (sync_in[g])
    );
    qpd_axis #(.CNT_W(CNT_W)) u_dec (
      .clk   (clk),
      .rst_n (rst_n_q),
      .ph_a  (sync_in[g][2]),
      .ph_b  (sync_in[g][1]),
      .idx   (sync_in[g][0]),
      .pos   (pos_cnt[g]),
      .err   (err_bits[g])
    );
    always_comb begin
      snap_d[g] = snap_i ? pos_cnt[g] : snap_q[g];
    end
    always_ff @(posedge clk or negedge rst_n_q) begin
      if (!rst_n_q) snap_q[g] <= '0;
      else          snap_q[g] <= snap_d[g];
    end
  end

  always_comb begin
    rd_d = rd_data;
    if (rd_en) begin
      case (qpd_addr_e'(rd_addr))
        ADDR_AZ:  rd_d = snap_q[AXIS_AZ];
        ADDR_RL:  rd_d = snap_q[AXIS_RL];
        ADDR_ERR: rd_d = {{PAD_W{1'b0}}, err_bits};
        default:  rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_q) begin
    if (!rst_n_q) rd_data <= '0;
    else          rd_data <= rd_d;
  end
endmodule

// File: rtl/quad_pos_dual_chk.sv
module quad_pos_dual_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt_az,
  input logic [CNT_W-1:0] cnt_rl,
  input logic             idx_az,
  input logic             idx_rl,
  input logic [1:0]       err,
  input logic [CNT_W-1:0] snap_az,
  input logic [CNT_W-1:0] snap_rl,
  input logic             snap_i,
  input logic             rd_en,
  input logic [CNT_W-1:0] rd_data
);
  p_step_az_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_az == $past(cnt_az)) || (cnt_az == CNT_W'($past(cnt_az) + 1'b1)) ||
    (cnt_az == CNT_W'($past(cnt_az) - 1'b1)) || (cnt_az == '0));

  p_step_rl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_rl == $past(cnt_rl)) || (cnt_rl == CNT_W'($past(cnt_rl) + 1'b1)) ||
    (cnt_rl == CNT_W'($past(cnt_rl) - 1'b1)) || (cnt_rl == '0));

  p_index_az_r6: assert property (@(posedge clk) disable iff (!rst_n)
    idx_az |=> (cnt_az == '0));

  p_index_rl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    idx_rl |=> (cnt_rl == '0));

  p_err_sticky_az_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err[0] |=> err[0]);

  p_err_sticky_rl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err[1] |=> err[1]);

  p_snap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_i |=> ($stable(snap_az) && $stable(snap_rl)));

  p_snap_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    snap_i |=> ((snap_az == $past(cnt_az)) && (snap_rl == $past(cnt_rl))));

  p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

bind quad_pos_dual quad_pos_dual_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n_q),
  .cnt_az  (pos_cnt[0]),
  .cnt_rl  (pos_cnt[1]),
  .idx_az  (sync_in[0][0]),
  .idx_rl  (sync_in[1][0]),
  .err     (err_bits),
  .snap_az (snap_q[0]),
  .snap_rl (snap_q[1]),
  .snap_i  (snap_i),
  .rd_en   (rd_en),
  .rd_data (rd_data)
);

// File: tb/quad_pos_dual_bench.sv
`timescale 1ns/1ps
module quad_pos_dual_bench;
  localparam int W = 8;
  localparam int MASK = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic az_a = 0, az_b = 0, az_z = 0, rl_a = 0, rl_b = 0, rl_z = 0;
  logic snap_i = 0, rd_en = 0;
  logic [1:0] rd_addr = 2'd0;
  logic [W-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int exp_pos [2];
  logic [1:0] ab [2];

  always #5 clk = ~clk;

  quad_pos_dual #(.CNT_W(W)) u_quad_pos_dual (
    .clk(clk), .rst_n(rst_n),
    .az_a(az_a), .az_b(az_b), .az_z(az_z),
    .rl_a(rl_a), .rl_b(rl_b), .rl_z(rl_z),
    .snap_i(snap_i), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input int ax, input logic [1:0] v, input logic z);
    ab[ax] = v;
    if (ax == 0) begin az_a = v[1]; az_b = v[0]; az_z = z; end
    else         begin rl_a = v[1]; rl_b = v[0]; rl_z = z; end
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [1:0] nxt(input logic [1:0] s, input bit up);
    if (up) return (s == 2'b00) ? 2'b10 : (s == 2'b10) ? 2'b11 : (s == 2'b11) ? 2'b01 : 2'b00;
    else    return (s == 2'b00) ? 2'b01 : (s == 2'b01) ? 2'b11 : (s == 2'b11) ? 2'b10 : 2'b00;
  endfunction

  task automatic move(input int ax, input bit up);
    drive(ax, nxt(ab[ax], up), 1'b0);
    exp_pos[ax] = (exp_pos[ax] + (up ? 1 : -1)) & MASK;
  endtask

  task automatic latch();
    snap_i = 1'b1;
    @(negedge clk);
    snap_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = int'(rd_data);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int v, old;
    exp_pos[0] = 0; exp_pos[1] = 0; ab[0] = 2'b00; ab[1] = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    check("R10 rd_data", int'(rd_data), 0);
    rd(2'd0, v); check("R10 az snapshot", v, 0);
    rd(2'd1, v); check("R10 rl snapshot", v, 0);
    rd(2'd2, v); check("R10 error bits", v, 0);

    // R1: one edge, counter must not change before the third edge
    drive(0, 2'b10, 1'b0);
    drive(0, 2'b00, 1'b0);
    az_a = 1'b1; ab[0] = 2'b10;
    @(negedge clk); latch(); rd(2'd0, v); check("R1 early", v, 0);
    @(negedge clk); latch(); rd(2'd0, v); check("R1 settled", v, 1);
    exp_pos[0] = 1;

    // R2 / R5 sweep azimuth upwards across the wrap
    for (int i = 0; i < 300; i++) begin
      move(0, 1'b1); latch(); rd(2'd0, v);
      check("R2 R5 az up", v, exp_pos[0]);
    end
    rd(2'd1, v); check("R7 rl untouched", v, 0);

    // R3 / R5 sweep roll downwards across zero and the wrap
    for (int i = 0; i < 300; i++) begin
      move(1, 1'b0); latch(); rd(2'd1, v);
      check("R3 R5 rl down", v, exp_pos[1]);
    end
    rd(2'd0, v); check("R7 az untouched", v, exp_pos[0]);

    // R8 snapshot holds between strobes
    latch(); rd(2'd0, old);
    move(0, 1'b1); move(0, 1'b1);
    rd(2'd0, v); check("R8 stale snapshot", v, old);
    latch(); rd(2'd0, v); check("R8 new snapshot", v, exp_pos[0]);

    // R4 illegal double change on roll
    drive(1, ~ab[1], 1'b0);
    latch(); rd(2'd1, v); check("R4 rl unchanged", v, exp_pos[1]);
    rd(2'd2, v); check("R4 rl error bit", v, 2);
    move(1, 1'b1); move(1, 1'b1);
    latch(); rd(2'd1, v); check("R4 rl resumes", v, exp_pos[1]);
    rd(2'd2, v); check("R4 sticky", v, 2);
    drive(0, ~ab[0], 1'b0);
    rd(2'd2, v); check("R4 both errors", v, 3);

    // R6 index wins over a simultaneous step
    drive(0, nxt(ab[0], 1'b1), 1'b1);
    az_z = 1'b0; repeat (4) @(negedge clk);
    exp_pos[0] = 0;
    latch(); rd(2'd0, v); check("R6 az cleared", v, 0);
    rd(2'd1, v); check("R7 rl kept", v, exp_pos[1]);
    move(0, 1'b0);
    latch(); rd(2'd0, v); check("R6 az after index", v, MASK);
    drive(1, ab[1], 1'b1);
    rl_z = 1'b0; repeat (4) @(negedge clk);
    exp_pos[1] = 0;
    latch(); rd(2'd1, v); check("R6 rl cleared", v, 0);
    rd(2'd0, v); check("R7 az kept", v, MASK);

    // R9 read port
    rd(2'd3, v); check("R9 addr3 zero", v, 0);
    rd(2'd0, old);
    move(0, 1'b1); latch(); repeat (2) @(negedge clk);
    check("R9 hold while idle", int'(rd_data), old);
    rd(2'd0, v); check("R9 fresh read", v, exp_pos[0]);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule